// File: doc/BRIEF.md
# Full-Rate to Half-Rate Command Gearbox

This block sits between user logic that issues memory commands at the external memory clock rate and a controller core that runs at half that rate. In every fast cycle the user side can present one read command and one write command together. Each command has its own address, and the write carries its data word and byte-write enables. The block gathers two consecutive fast cycles into one double-width word for the core. Each slot in that word has its own valid flag, so a command that arrives in only one cycle of the pair is neither lost nor repeated.

In the return direction the core hands over two read-data words per slow cycle, each with a valid flag. The block plays them back to the user one word per fast cycle, earlier slot first, with a one-bit strobe. The block runs on the fast clock and keeps its own phase toggle. The core's clock is taken to be the fast clock divided by two, with its rising edge on the fast edge that ends the second (late) fast cycle of a pair. When user logic already runs at half rate, the `BYPASS` parameter replaces the conversion with one register stage per direction. In that case `clk` is the half-rate clock and the user ports are two slots wide.

Top module: `hr_cmd_gearbox`

## Requirements
- R1: Synchronous active-high reset clears every read and write valid flag on the core side and the read strobe on the user side. It also returns the phase to the early half: the first fast cycle after reset release is slot 0.
- R2: Read commands from fast cycles 2k and 2k+1 after reset appear on the core read port after the fast edge that ends cycle 2k+1. Slot 0 (low bits of the flag and address buses) holds cycle 2k and slot 1 holds cycle 2k+1. No command is reordered.
- R3: Write address, write data and byte enables are packed in the same way and with the same timing as reads, independently of the read channel. Slot s of each bus sits at bits [s*W +: W] for field width W.
- R4: Each slot's core read and write flag equals the user request of the fast cycle it was captured in. A command present in only one cycle of a pair leaves the other slot's flag at 0.
- R5: A read word the core presents during a slow cycle is returned to the user as slot 0 in the first fast cycle after that slow cycle's closing edge, and as slot 1 in the next fast cycle.
- R6: The user read strobe is 1 exactly in the fast cycles whose slot flag from the core was 1, and 0 for slots marked invalid.
- R7: Core-side outputs change only at the fast edge that ends a late cycle. They hold for both fast cycles of each slow cycle.
- R8: With BYPASS=1, user ports are two slots wide. Every core-side output equals the matching user input of the previous clock cycle, and every user read output equals the core read input of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (half-rate clock when BYPASS=1) |
| rst | input | 1 | Synchronous active-high reset |
| usr_rd_req | input | US | Read command request per user slot |
| usr_rd_addr | input | US*AW | Read address per user slot |
| usr_wr_req | input | US | Write command request per user slot |
| usr_wr_addr | input | US*AW | Write address per user slot |
| usr_wr_data | input | US*DW | Write data per user slot |
| usr_wr_be | input | US*BW | Byte-write enables per user slot, BW = DW/9 |
| usr_rd_valid | output | US | Read-data strobe per user slot |
| usr_rd_data | output | US*DW | Read data per user slot |
| core_rd_req | output | 2 | Read flag per core slot |
| core_rd_addr | output | 2*AW | Read address per core slot |
| core_wr_req | output | 2 | Write flag per core slot |
| core_wr_addr | output | 2*AW | Write address per core slot |
| core_wr_data | output | 2*DW | Write data per core slot |
| core_wr_be | output | 2*BW | Byte enables per core slot |
| core_rd_valid | input | 2 | Read-data flag per core slot |
| core_rd_data | input | 2*DW | Read data per core slot |

US is 1 normally and 2 when BYPASS=1.

## Verification
The stimulus runs through several phases. In the first, both channels are busy every fast cycle, which exposes any swapped slot or field. Next, reads occur only in early cycles and writes only in late cycles, so a flag copied into the wrong slot, or a read slot taken from the write channel, shows up at once. An idle stretch and a pseudo-random stretch follow; these catch stuck or duplicated flags. Returned read words cycle through all four slot-flag combinations, which separates strobe gating from the order of word playback. A second instance with the bypass variant is checked for a one-cycle pass-through of every field.

// File: rtl/hr_gearbox_pkg.sv
`timescale 1ns/1ps
package hr_gearbox_pkg;
  // one byte-enable bit covers this many data bits
  parameter int unsigned BE_LANE_BITS = 9;

  // which half of the slow cycle the current fast cycle is
  typedef enum logic {PH_EARLY = 1'b0, PH_LATE = 1'b1} phase_e;
endpackage

// File: rtl/hr_phase.sv
`timescale 1ns/1ps
module hr_phase
  import hr_gearbox_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e ph
);
  always_ff @(posedge clk) begin
    if (rst) ph <= PH_EARLY;
    else     ph <= (ph == PH_EARLY) ? PH_LATE : PH_EARLY;
  end
endmodule

// File: rtl/hr_slot_pack.sv
`timescale 1ns/1ps
// Collects one item per fast cycle into a two-slot word that updates once
// per slow cycle: slot 0 = early cycle, slot 1 = late cycle.
module hr_slot_pack #(
  parameter int W = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           late,
  input  logic           in_vld,
  input  logic [W-1:0]   in_dat,
  output logic [1:0]     out_vld,
  output logic [2*W-1:0] out_dat
);
  logic         hold_vld;
  logic [W-1:0] hold_dat;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld <= 1'b0;
      out_vld  <= 2'b00;
    end else if (!late) begin
      hold_vld <= in_vld;
    end else begin
      out_vld  <= {in_vld, hold_vld};
    end
  end

  always_ff @(posedge clk) begin
    if (!late) hold_dat <= in_dat;
    else       out_dat  <= {in_dat, hold_dat};
  end
endmodule

// File: rtl/hr_slot_unpack.sv
`timescale 1ns/1ps
// Takes a two-slot word at the slow edge and replays it one slot per fast
// cycle, slot 0 first.
module hr_slot_unpack #(
  parameter int W = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           late,
  input  logic [1:0]     in_vld,
  input  logic [2*W-1:0] in_dat,
  output logic           out_vld,
  output logic [W-1:0]   out_dat
);
  logic         hold_vld;
  logic [W-1:0] hold_dat;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld <= 1'b0;
      out_vld  <= 1'b0;
    end else if (late) begin
      out_vld  <= in_vld[0];
      hold_vld <= in_vld[1];
    end else begin
      out_vld  <= hold_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (late) begin
      out_dat  <= in_dat[W-1:0];
      hold_dat <= in_dat[2*W-1:W];
    end else begin
      out_dat  <= hold_dat;
    end
  end
endmodule

// File: rtl/hr_pass_reg.sv
`timescale 1ns/1ps
// Bypass variant: one register stage on a two-slot word.
module hr_pass_reg #(
  parameter int W = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     in_vld,
  input  logic [2*W-1:0] in_dat,
  output logic [1:0]     out_vld,
  output logic [2*W-1:0] out_dat
);
  always_ff @(posedge clk) begin
    if (rst) out_vld <= 2'b00;
    else     out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    out_dat <= in_dat;
  end
endmodule

// File: rtl/hr_cmd_gearbox.sv
`timescale 1ns/1ps
module hr_cmd_gearbox
  import hr_gearbox_pkg::*;
#(
  parameter  int AW     = 20,
  parameter  int DW     = 18,
  parameter  int BYPASS = 0,
  localparam int BW     = DW / BE_LANE_BITS,
  localparam int US     = (BYPASS != 0) ? 2 : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [US-1:0]   usr_rd_req,
  input  logic [US*AW-1:0] usr_rd_addr,
  input  logic [US-1:0]   usr_wr_req,
  input  logic [US*AW-1:0] usr_wr_addr,
  input  logic [US*DW-1:0] usr_wr_data,
  input  logic [US*BW-1:0] usr_wr_be,
  output logic [US-1:0]   usr_rd_valid,
  output logic [US*DW-1:0] usr_rd_data,
  output logic [1:0]      core_rd_req,
  output logic [2*AW-1:0] core_rd_addr,
  output logic [1:0]      core_wr_req,
  output logic [2*AW-1:0] core_wr_addr,
  output logic [2*DW-1:0] core_wr_data,
  output logic [2*BW-1:0] core_wr_be,
  input  logic [1:0]      core_rd_valid,
  input  logic [2*DW-1:0] core_rd_data
);
  localparam int WW = AW + DW + BW;   // one write slot: {be, data, addr}

  logic [US*WW-1:0] usr_wr_bus;
  logic [2*WW-1:0]  core_wr_bus;

  for (genvar s = 0; s < US; s++) begin : g_usr_wr
    assign usr_wr_bus[s*WW +: WW] =
      {usr_wr_be[s*BW +: BW], usr_wr_data[s*DW +: DW], usr_wr_addr[s*AW +: AW]};
  end

  for (genvar s = 0; s < 2; s++) begin : g_core_wr
    assign {core_wr_be[s*BW +: BW], core_wr_data[s*DW +: DW], core_wr_addr[s*AW +: AW]} =
      core_wr_bus[s*WW +: WW];
  end

  if (BYPASS == 0) begin : g_gear
    phase_e ph;
    logic   late;

    hr_phase u_phase (.clk(clk), .rst(rst), .ph(ph));
    assign late = (ph == PH_LATE);

    hr_slot_pack #(.W(AW)) u_rd_pack (
      .clk(clk), .rst(rst), .late(late),
      .in_vld(usr_rd_req), .in_dat(usr_rd_addr),
      .out_vld(core_rd_req), .out_dat(core_rd_addr));

    hr_slot_pack #(.W(WW)) u_wr_pack (
      .clk(clk), .rst(rst), .late(late),
      .in_vld(usr_wr_req), .in_dat(usr_wr_bus),
      .out_vld(core_wr_req), .out_dat(core_wr_bus));

    hr_slot_unpack #(.W(DW)) u_ret_unpack (
      .clk(clk), .rst(rst), .late(late),
      .in_vld(core_rd_valid), .in_dat(core_rd_data),
      .out_vld(usr_rd_valid), .out_dat(usr_rd_data));
  end else begin : g_bypass
    hr_pass_reg #(.W(AW)) u_rd_pass (
      .clk(clk), .rst(rst),
      .in_vld(usr_rd_req), .in_dat(usr_rd_addr),
      .out_vld(core_rd_req), .out_dat(core_rd_addr));

    hr_pass_reg #(.W(WW)) u_wr_pass (
      .clk(clk), .rst(rst),
      .in_vld(usr_wr_req), .in_dat(usr_wr_bus),
      .out_vld(core_wr_req), .out_dat(core_wr_bus));

    hr_pass_reg #(.W(DW)) u_ret_pass (
      .clk(clk), .rst(rst),
      .in_vld(core_rd_valid), .in_dat(core_rd_data),
      .out_vld(usr_rd_valid), .out_dat(usr_rd_data));
  end
endmodule

// File: rtl/hr_gearbox_chk.sv
`timescale 1ns/1ps
module hr_gearbox_chk #(
  parameter int AW     = 20,
  parameter int BYPASS = 0,
  parameter int US     = 1
) (
  input logic            clk,
  input logic            rst,
  input logic [US-1:0]   usr_rd_req,
  input logic [US-1:0]   usr_wr_req,
  input logic [US-1:0]   usr_rd_valid,
  input logic [1:0]      core_rd_req,
  input logic [1:0]      core_wr_req,
  input logic [2*AW-1:0] core_rd_addr,
  input logic [1:0]      core_rd_valid
);
  // checker-owned phase and cycles-since-reset, independent of the design
  logic       ph;
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= 1'b0;
      seen <= 2'd0;
    end else begin
      ph   <= ~ph;
      seen <= (seen == 2'd3) ? seen : seen + 2'd1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (core_rd_req == 2'b00 && core_wr_req == 2'b00 && usr_rd_valid == '0)); // R1

  if (BYPASS == 0) begin : g_fast
    AST_RD_PACK_ORDER: assert property (@(posedge clk) disable iff (rst)
      (!ph && seen >= 2'd2) |-> core_rd_req == {$past(usr_rd_req), $past(usr_rd_req, 2)}); // R2
    AST_WR_SLOT_FLAGS: assert property (@(posedge clk) disable iff (rst)
      (!ph && seen >= 2'd2) |-> core_wr_req == {$past(usr_wr_req), $past(usr_wr_req, 2)}); // R4
    AST_RET_SLOT0: assert property (@(posedge clk) disable iff (rst)
      (!ph && seen >= 2'd2) |-> usr_rd_valid == $past(core_rd_valid[0])); // R5
    AST_RET_SLOT1: assert property (@(posedge clk) disable iff (rst)
      (ph && seen >= 2'd2) |-> usr_rd_valid == $past(core_rd_valid[1], 2)); // R6
    AST_SLOW_STABLE: assert property (@(posedge clk) disable iff (rst)
      (ph && seen != 2'd0) |-> ($stable(core_rd_req) && $stable(core_wr_req) && $stable(core_rd_addr))); // R7
  end else begin : g_byp
    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
      (seen != 2'd0) |-> (core_rd_req == $past(usr_rd_req) && core_wr_req == $past(usr_wr_req)
                          && usr_rd_valid == $past(core_rd_valid))); // R8
  end
endmodule

bind hr_cmd_gearbox hr_gearbox_chk #(.AW(AW), .BYPASS(BYPASS), .US(US)) u_chk (
  .clk(clk), .rst(rst),
  .usr_rd_req(usr_rd_req), .usr_wr_req(usr_wr_req), .usr_rd_valid(usr_rd_valid),
  .core_rd_req(core_rd_req), .core_wr_req(core_wr_req), .core_rd_addr(core_rd_addr),
  .core_rd_valid(core_rd_valid));

// File: tb/sim_hr_cmd_gearbox.sv
`timescale 1ns/1ps
module sim_hr_cmd_gearbox;
  localparam int AW = 20;
  localparam int DW = 18;
  localparam int BW = 2;
  localparam int N  = 120;

  typedef struct packed {
    logic [1:0]      rv;
    logic [2*AW-1:0] ra;
    logic [1:0]      wv;
    logic [2*AW-1:0] wa;
    logic [2*DW-1:0] wd;
    logic [2*BW-1:0] be;
  } cmd_t;

  typedef struct packed {
    logic          v;
    logic [DW-1:0] d;
  } ret_t;

  typedef struct packed {
    cmd_t            cmd;
    logic [1:0]      v;
    logic [2*DW-1:0] d;
  } byp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go  = 1'b0;
  always #2.5 clk = ~clk;

  // u0: full-rate variant
  logic            u0_rd_req, u0_wr_req, u0_urv;
  logic [AW-1:0]   u0_rd_addr, u0_wr_addr;
  logic [DW-1:0]   u0_wr_data, u0_urd;
  logic [BW-1:0]   u0_wr_be;
  logic [1:0]      c0_rd_req, c0_wr_req, c0_rvld;
  logic [2*AW-1:0] c0_rd_addr, c0_wr_addr;
  logic [2*DW-1:0] c0_wr_data, c0_rdat;
  logic [2*BW-1:0] c0_wr_be;

  // u1: bypass variant
  logic [1:0]      u1_rd_req, u1_wr_req, u1_urv;
  logic [2*AW-1:0] u1_rd_addr, u1_wr_addr;
  logic [2*DW-1:0] u1_wr_data, u1_urd;
  logic [2*BW-1:0] u1_wr_be;
  logic [1:0]      c1_rd_req, c1_wr_req, c1_rvld;
  logic [2*AW-1:0] c1_rd_addr, c1_wr_addr;
  logic [2*DW-1:0] c1_wr_data, c1_rdat;
  logic [2*BW-1:0] c1_wr_be;

  hr_cmd_gearbox #(.AW(AW), .DW(DW), .BYPASS(0)) u0 (
    .clk(clk), .rst(rst),
    .usr_rd_req(u0_rd_req), .usr_rd_addr(u0_rd_addr),
    .usr_wr_req(u0_wr_req), .usr_wr_addr(u0_wr_addr),
    .usr_wr_data(u0_wr_data), .usr_wr_be(u0_wr_be),
    .usr_rd_valid(u0_urv), .usr_rd_data(u0_urd),
    .core_rd_req(c0_rd_req), .core_rd_addr(c0_rd_addr),
    .core_wr_req(c0_wr_req), .core_wr_addr(c0_wr_addr),
    .core_wr_data(c0_wr_data), .core_wr_be(c0_wr_be),
    .core_rd_valid(c0_rvld), .core_rd_data(c0_rdat));

  hr_cmd_gearbox #(.AW(AW), .DW(DW), .BYPASS(1)) u1 (
    .clk(clk), .rst(rst),
    .usr_rd_req(u1_rd_req), .usr_rd_addr(u1_rd_addr),
    .usr_wr_req(u1_wr_req), .usr_wr_addr(u1_wr_addr),
    .usr_wr_data(u1_wr_data), .usr_wr_be(u1_wr_be),
    .usr_rd_valid(u1_urv), .usr_rd_data(u1_urd),
    .core_rd_req(c1_rd_req), .core_rd_addr(c1_rd_addr),
    .core_wr_req(c1_wr_req), .core_wr_addr(c1_wr_addr),
    .core_wr_data(c1_wr_data), .core_wr_be(c1_wr_be),
    .core_rd_valid(c1_rvld), .core_rd_data(c1_rdat));

  int n_chk  = 0;
  int n_fail = 0;
  cmd_t cmd_q[$];
  ret_t ret_q[$];
  byp_t byp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // stimulus patterns: busy, alternating, idle, scrambled
  function automatic logic f_rd(int c);
    if (c < 16) return 1'b1;
    if (c < 32) return (c % 2) == 0;
    if (c < 48) return 1'b0;
    return ((c * 7 + 3) % 5) < 2;
  endfunction
  function automatic logic f_wr(int c);
    if (c < 16) return 1'b1;
    if (c < 32) return (c % 2) == 1;
    if (c < 48) return (c % 4) == 1;
    return ((c * 11 + 1) % 3) == 0;
  endfunction
  function automatic logic [AW-1:0] f_ra(int c); return AW'(32'h10000 + c * 3); endfunction
  function automatic logic [AW-1:0] f_wa(int c); return AW'(32'h20000 ^ (c * 5)); endfunction
  function automatic logic [DW-1:0] f_wd(int c); return DW'(c * 37 + 5); endfunction
  function automatic logic [BW-1:0] f_be(int c); return BW'(c); endfunction
  function automatic logic [1:0] f_rv(int m);
    if (m < 8)  return 2'b11;
    if (m < 16) return 2'b01;
    if (m < 24) return 2'b10;
    if (m < 32) return 2'b00;
    return 2'((m * 5 + 1) % 4);
  endfunction
  function automatic logic [DW-1:0] f_rdat(int m, int i); return DW'(m * 101 + i * 7 + 1); endfunction

  // two fast cycles a (slot 0) and a+1 (slot 1) as one core word
  function automatic cmd_t mk_cmd(int a);
    cmd_t t;
    t.rv = {f_rd(a + 1), f_rd(a)};
    t.ra = {f_ra(a + 1), f_ra(a)};
    t.wv = {f_wr(a + 1), f_wr(a)};
    t.wa = {f_wa(a + 1), f_wa(a)};
    t.wd = {f_wd(a + 1), f_wd(a)};
    t.be = {f_be(a + 1), f_be(a)};
    return t;
  endfunction

  // driver
  initial begin
    cmd_t t;
    byp_t b;
    u0_rd_req = 0; u0_wr_req = 0; u0_rd_addr = 0; u0_wr_addr = 0; u0_wr_data = 0; u0_wr_be = 0;
    c0_rvld = 2'b11; c0_rdat = 0;
    u1_rd_req = 2'b11; u1_wr_req = 2'b11; u1_rd_addr = 0; u1_wr_addr = 0; u1_wr_data = 0; u1_wr_be = 0;
    c1_rvld = 2'b11; c1_rdat = 0;
    repeat (4) @(negedge clk);
    // R1: reset state while inputs request everything
    chk(c0_rd_req == 2'b00 && c0_wr_req == 2'b00, "R1 core flags u0", 128'({c0_rd_req, c0_wr_req}), 128'(0));
    chk(u0_urv == 1'b0, "R1 user strobe u0", 128'(u0_urv), 128'(0));
    chk(c1_rd_req == 2'b00 && c1_wr_req == 2'b00 && u1_urv == 2'b00, "R1 flags u1",
        128'({c1_rd_req, c1_wr_req, u1_urv}), 128'(0));
    for (int c = 0; c < N; c++) begin
      @(negedge clk);
      if (c == 0) begin rst = 1'b0; go = 1'b1; end
      u0_rd_req = f_rd(c); u0_rd_addr = f_ra(c);
      u0_wr_req = f_wr(c); u0_wr_addr = f_wa(c); u0_wr_data = f_wd(c); u0_wr_be = f_be(c);
      if (c % 2 == 0) begin
        c0_rvld = f_rv(c / 2);
        c0_rdat = {f_rdat(c / 2, 1), f_rdat(c / 2, 0)};
        ret_q.push_back('{v: c0_rvld[0], d: c0_rdat[DW-1:0]});
        ret_q.push_back('{v: c0_rvld[1], d: c0_rdat[2*DW-1:DW]});
      end else begin
        cmd_q.push_back(mk_cmd(c - 1));
      end
      t = mk_cmd(2 * c + 200);
      u1_rd_req = t.rv; u1_rd_addr = t.ra; u1_wr_req = t.wv;
      u1_wr_addr = t.wa; u1_wr_data = t.wd; u1_wr_be = t.be;
      c1_rvld = f_rv(c + 60);
      c1_rdat = {f_rdat(c + 60, 1), f_rdat(c + 60, 0)};
      b.cmd = t; b.v = c1_rvld; b.d = c1_rdat;
      byp_q.push_back(b);
    end
  end

  // monitor
  initial begin
    cmd_t act, last, e;
    ret_t r;
    byp_t b;
    last = '0;
    wait (go);
    for (int c = 0; c < N; c++) begin
      @(posedge clk);
      #1;
      act = {c0_rd_req, c0_rd_addr, c0_wr_req, c0_wr_addr, c0_wr_data, c0_wr_be};
      if (c % 2 == 1) begin
        if (cmd_q.size() == 0) chk(1'b0, "R2 queue empty", 0, 0);
        else begin
          e = cmd_q.pop_front();
          chk(act.rv == e.rv, "R4 read slot flags", 128'(act.rv), 128'(e.rv));
          chk(act.ra == e.ra, "R2 read slot addresses", 128'(act.ra), 128'(e.ra));
          chk(act.wv == e.wv, "R4 write slot flags", 128'(act.wv), 128'(e.wv));
          chk({act.wa, act.wd, act.be} == {e.wa, e.wd, e.be}, "R3 write slots",
              128'({act.wa, act.wd, act.be}), 128'({e.wa, e.wd, e.be}));
        end
      end else if (c >= 2) begin
        chk(act == last, "R7 core word held across slow cycle", 128'(act), 128'(last));
      end
      last = act;
      if (c >= 1) begin
        if (ret_q.size() == 0) chk(1'b0, "R5 queue empty", 0, 0);
        else begin
          r = ret_q.pop_front();
          chk(u0_urv == r.v, "R6 read strobe", 128'(u0_urv), 128'(r.v));
          if (r.v) chk(u0_urd == r.d, "R5 read word order", 128'(u0_urd), 128'(r.d));
        end
      end
      b = byp_q.pop_front();
      chk({c1_rd_req, c1_rd_addr, c1_wr_req, c1_wr_addr, c1_wr_data, c1_wr_be} == b.cmd,
          "R8 bypass commands", 128'({c1_rd_req, c1_rd_addr, c1_wr_req, c1_wr_addr}),
          128'({b.cmd.rv, b.cmd.ra, b.cmd.wv, b.cmd.wa}));
      chk(u1_urv == b.v && u1_urd == b.d, "R8 bypass read return", 128'({u1_urv, u1_urd}), 128'({b.v, b.d}));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule